// File: doc/BRIEF.md
# Configuration Space Address/Data Port Decoder

This block sits on the host side of a system and turns accesses on a small I/O port bus into configuration-space cycles. Software first writes a 32-bit target word into an address port. That word names an enable flag, a bus number, a device/function slot and a dword-aligned register offset. Byte, word or dword accesses to a 4-byte data window are then forwarded as single-cycle configuration read or write strobes to the chosen slot. The strobes carry a byte offset, which joins the latched dword offset with the byte lane used on the data window, and the access width.

Only bus 0 is served. A data-window access is dropped without any strobe in five cases: the enable flag is clear, the two low bits of the latched target are non-zero, the bus is non-zero, the slot is not marked present, or the width code is illegal. A dropped read returns all ones at the requested width. Slot presence comes from a 256-bit input vector, one bit per slot. Read data from the slot goes back to the port bus combinationally, in the same cycle as the access.

Top module: `cfgdec_top`

## Requirements
- R1: After reset the target register reads 0. A dword write (io_size code 2) at exactly port 0xCF8 loads io_wdata into the register at the next clock edge. A dword read at 0xCF8 returns the stored value in the same cycle.
- R2: At ports 0xCF8..0xCFB, any access that is not a dword at 0xCF8 leaves the target register unchanged. Such a read returns all ones at the requested width.
- R3: When bit 31 of the target register is 0, a data-window access (ports 0xCFC..0xCFF) raises neither cfg_wr nor cfg_rd, and a read returns all ones at the requested width.
- R4: When bits 1:0 of the target register are non-zero, a data-window access is dropped in the same way as in R3.
- R5: When bits 23:16 (bus) of the target register are non-zero, a data-window access is dropped in the same way as in R3.
- R6: cfg_slot equals bits 15:8 of the target register. If slot_present[cfg_slot] is 0, the access is dropped in the same way as in R3.
- R7: cfg_offset equals bits 7:2 of the target register in its upper six bits and io_addr[1:0] in its lower two bits.
- R8: The width code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) is passed to cfg_size unchanged. Code 3 is illegal: the access is dropped and a read returns 0xFFFFFFFF.
- R9: A read that is not dropped raises cfg_rd for that cycle and returns cfg_rdata masked to the width (0xFF, 0xFFFF or all 32 bits), with the upper bits zero.
- R10: A write that is not dropped raises cfg_wr for that cycle only, with cfg_wdata equal to io_wdata. When io_wr and io_rd are both high, only the write is performed.
- R11: An access outside 0xCF8..0xCFF raises no strobe, leaves the target register unchanged, and a read returns 0.
- All ones "at the requested width" means 0x000000FF, 0x0000FFFF or 0xFFFFFFFF for codes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Access width code: 0 byte, 1 word, 2 dword, 3 illegal |
| io_rd | input | 1 | Read access this cycle |
| io_wr | input | 1 | Write access this cycle |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid in the access cycle |
| slot_present | input | 256 | One bit per device/function slot, 1 = occupied |
| cfg_rdata | input | 32 | Data returned by the selected slot |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_rd | output | 1 | Configuration read strobe |
| cfg_slot | output | 8 | Selected device/function slot |
| cfg_offset | output | 8 | Byte offset in the slot's configuration space |
| cfg_size | output | 2 | Access width code forwarded to the slot |
| cfg_wdata | output | 32 | Write data forwarded to the slot |

## Verification
Strobes, slot, offset, width and read data are all combinational from the current access and the stored target. The bench therefore drives each access on a falling edge and compares these outputs one time unit later, before the next rising edge. The target register is the only state, and it takes a new value one rising edge after an accepted write. The bench's own copy of that register is updated at the same edge, so every later access is predicted from the value the design holds at that time.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    // Layout of the latched target word (field positions are decoded)
    typedef struct packed {
        logic       enable;
        logic [6:0] spare;
        logic [7:0] bus;
        logic [7:0] slot;
        logic [5:0] dword;
        logic [1:0] align;
    } tgt_addr_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] slot;
        logic [7:0] offset;
        acc_size_e  size;
    } cfg_req_t;

    function automatic logic [31:0] lane_mask(acc_size_e s);
        case (s)
            SZ_BYTE:  return 32'h0000_00FF;
            SZ_WORD:  return 32'h0000_FFFF;
            default:  return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic size_legal(acc_size_e s);
        return s != SZ_RSVD;
    endfunction

endpackage

// File: rtl/cfgdec_port_decode.sv
module cfgdec_port_decode
    import cfgdec_pkg::*;
#(
    parameter int unsigned IO_AW     = 16,
    parameter int unsigned ADDR_PORT = 32'h0CF8,
    parameter int unsigned DATA_PORT = 32'h0CFC
) (
    input  logic [IO_AW-1:0] io_addr,
    input  acc_size_e        io_size,
    output logic             addr_win,
    output logic             addr_exact,
    output logic             data_win,
    output logic [1:0]       lane
);
    localparam int unsigned   WIN_W    = IO_AW - 2;
    localparam logic [WIN_W-1:0] ADDR_IDX = WIN_W'(ADDR_PORT >> 2);
    localparam logic [WIN_W-1:0] DATA_IDX = WIN_W'(DATA_PORT >> 2);

    assign lane       = io_addr[1:0];
    assign addr_win   = (io_addr[IO_AW-1:2] == ADDR_IDX);
    assign data_win   = (io_addr[IO_AW-1:2] == DATA_IDX);
    assign addr_exact = addr_win && (lane == 2'b00) && (io_size == SZ_DWORD);
endmodule

// File: rtl/cfgdec_addr_reg.sv
module cfgdec_addr_reg
    import cfgdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  tgt_addr_t d,
    output tgt_addr_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/cfgdec_target_gate.sv
module cfgdec_target_gate
    import cfgdec_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 256
) (
    input  tgt_addr_t            tgt,
    input  logic [NUM_SLOTS-1:0] present,
    input  acc_size_e            size,
    input  logic [1:0]           lane,
    output cfg_req_t             req
);
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic in_range;
    logic occupied;
    logic [6:0] spare_unused;

    assign spare_unused = tgt.spare;
    assign in_range     = ({1'b0, tgt.slot} < 9'(NUM_SLOTS));
    assign occupied     = in_range && present[tgt.slot[SLOT_W-1:0]];

    always_comb begin
        req.slot   = tgt.slot;
        req.offset = {tgt.dword, lane};
        req.size   = size;
        req.valid  = tgt.enable
                  && (tgt.align == 2'b00)
                  && (tgt.bus == 8'h00)
                  && occupied
                  && size_legal(size);
    end
endmodule

// File: rtl/cfgdec_top.sv
module cfgdec_top
    import cfgdec_pkg::*;
#(
    parameter int unsigned IO_AW     = 16,
    parameter int unsigned ADDR_PORT = 32'h0CF8,
    parameter int unsigned DATA_PORT = 32'h0CFC,
    parameter int unsigned NUM_SLOTS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [1:0]           io_size,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [31:0]          io_wdata,
    output logic [31:0]          io_rdata,
    input  logic [NUM_SLOTS-1:0] slot_present,
    input  logic [31:0]          cfg_rdata,
    output logic                 cfg_wr,
    output logic                 cfg_rd,
    output logic [7:0]           cfg_slot,
    output logic [7:0]           cfg_offset,
    output logic [1:0]           cfg_size,
    output logic [31:0]          cfg_wdata
);
    acc_size_e  size_e;
    logic       addr_win, addr_exact, data_win;
    logic [1:0] lane;
    logic       tgt_we;
    tgt_addr_t  tgt_q;
    cfg_req_t   req;
    logic       rd_only;
    logic [31:0] mask;

    assign size_e  = acc_size_e'(io_size);
    assign rd_only = io_rd && !io_wr;
    assign mask    = lane_mask(size_e);

    cfgdec_port_decode #(
        .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
    ) u_decode (
        .io_addr(io_addr), .io_size(size_e),
        .addr_win(addr_win), .addr_exact(addr_exact),
        .data_win(data_win), .lane(lane)
    );

    assign tgt_we = io_wr && addr_exact;

    cfgdec_addr_reg u_tgt (
        .clk(clk), .rst(rst), .we(tgt_we),
        .d(tgt_addr_t'(io_wdata)), .q(tgt_q)
    );

    cfgdec_target_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
        .tgt(tgt_q), .present(slot_present),
        .size(size_e), .lane(lane), .req(req)
    );

    assign cfg_wr     = data_win && io_wr && req.valid;
    assign cfg_rd     = data_win && rd_only && req.valid;
    assign cfg_slot   = req.slot;
    assign cfg_offset = req.offset;
    assign cfg_size   = req.size;
    assign cfg_wdata  = io_wdata;

    always_comb begin
        io_rdata = '0;
        if (addr_win)
            io_rdata = addr_exact ? tgt_q : mask;
        else if (data_win)
            io_rdata = req.valid ? (cfg_rdata & mask) : mask;
    end

    AST_TGT_LOAD: assert property (@(posedge clk) disable iff (rst)
        tgt_we |=> (tgt_q == $past(io_wdata))); // R1
    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tgt_we |=> $stable(tgt_q)); // R2
    AST_WR_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> tgt_q.enable); // R3
    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> (tgt_q.align == 2'b00)); // R4
    AST_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> (tgt_q.bus == 8'h00)); // R5
    AST_SLOT_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> slot_present[cfg_slot]); // R6
    AST_OFFSET_LANE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> (cfg_offset[1:0] == io_addr[1:0])); // R7
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |-> (cfg_size != 2'd3)); // R8
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_rd)); // R10
endmodule

// File: tb/cfgdec_top_tb_top.sv
module cfgdec_top_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  io_addr = '0;
    logic [1:0]   io_size = '0;
    logic         io_rd = 1'b0, io_wr = 1'b0;
    logic [31:0]  io_wdata = '0, io_rdata;
    logic [255:0] slot_present = '0;
    logic [31:0]  cfg_rdata = '0;
    logic         cfg_wr, cfg_rd;
    logic [7:0]   cfg_slot, cfg_offset;
    logic [1:0]   cfg_size;
    logic [31:0]  cfg_wdata;

    int n_chk = 0, n_bad = 0;
    logic [31:0] m_tgt = '0;
    bit done = 0;

    always #2 clk = ~clk;

    cfgdec_top dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .slot_present(slot_present), .cfg_rdata(cfg_rdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_slot(cfg_slot),
        .cfg_offset(cfg_offset), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata)
    );

    function automatic logic [31:0] f_mask(logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    // Which requirement decides a data-window access
    function automatic string f_reason(logic [31:0] t, logic [1:0] s);
        if (!t[31])              return "R3";
        if (t[1:0] != 2'b00)     return "R4";
        if (t[23:16] != 8'h00)   return "R5";
        if (!slot_present[t[15:8]]) return "R6";
        if (s == 2'd3)           return "R8";
        return "R9";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic acc(logic [15:0] port, logic [1:0] sz, bit rd, bit wr, logic [31:0] wd);
        bit in_a, in_d, exact, ok;
        string why;
        logic [31:0] ex_rd;
        @(negedge clk);
        io_addr = port; io_size = sz; io_rd = rd; io_wr = wr;
        io_wdata = wd; cfg_rdata = $urandom;
        #1;
        in_a  = (port[15:2] == 14'(16'hCF8 >> 2));
        in_d  = (port[15:2] == 14'(16'hCFC >> 2));
        exact = in_a && port[1:0] == 2'b00 && sz == 2'd2;
        why   = in_d ? f_reason(m_tgt, sz) : (in_a ? "R2" : "R11");
        ok    = in_d && why == "R9";
        if (exact) why = "R1";
        if (in_a)      ex_rd = exact ? m_tgt : f_mask(sz);
        else if (in_d) ex_rd = ok ? (cfg_rdata & f_mask(sz)) : f_mask(sz);
        else           ex_rd = 32'h0;
        check({why, " wr strobe"}, 32'(cfg_wr), 32'(ok && wr));
        check({why, " rd strobe"}, 32'(cfg_rd), 32'(ok && rd && !wr));
        if (rd && !wr) check({why, " rdata"}, io_rdata, ex_rd);
        if (ok) begin
            check("R6 slot", 32'(cfg_slot), 32'(m_tgt[15:8]));
            check("R7 offset", 32'(cfg_offset), 32'({m_tgt[7:2], port[1:0]}));
            check("R8 size", 32'(cfg_size), 32'(sz));
            if (wr) check("R10 wdata", cfg_wdata, wd);
        end
        @(posedge clk);
        if (exact && wr) m_tgt = wd;
        #1; io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic set_tgt(bit en, logic [7:0] bus, logic [7:0] slot, logic [5:0] dw, logic [1:0] al);
        acc(16'hCF8, 2'd2, 0, 1, {en, 7'h00, bus, slot, dw, al});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) slot_present[i*32 +: 32] = $urandom;
        slot_present[8'h10] = 1'b1;
        slot_present[8'h11] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset value
        acc(16'hCF8, 2'd2, 1, 0, 0);
        // R1 load and read back
        set_tgt(1, 8'h00, 8'h10, 6'h05, 2'b00);
        acc(16'hCF8, 2'd2, 1, 0, 0);
        // R2 byte write to address window ignored, then readback
        acc(16'hCF9, 2'd0, 0, 1, 32'hDEAD_BEEF);
        acc(16'hCF8, 2'd1, 1, 0, 0);
        acc(16'hCF8, 2'd2, 1, 0, 0);
        // R11 outside both windows
        acc(16'hCF4, 2'd2, 0, 1, 32'h1234_5678);
        acc(16'hD00, 2'd2, 1, 0, 0);
        acc(16'hCF8, 2'd2, 1, 0, 0);
        // R7/R9 every lane and width
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 4; s++) begin
                acc(16'hCFC + 16'(l), 2'(s), 1, 0, 0);
                acc(16'hCFC + 16'(l), 2'(s), 0, 1, $urandom);
            end
        // R10 write wins over read
        acc(16'hCFE, 2'd1, 1, 1, 32'hCAFE_0001);
        // R3, R4, R5, R6 drops
        set_tgt(0, 8'h00, 8'h10, 6'h01, 2'b00); acc(16'hCFC, 2'd2, 1, 0, 0); acc(16'hCFD, 2'd0, 0, 1, 1);
        set_tgt(1, 8'h00, 8'h10, 6'h01, 2'b10); acc(16'hCFC, 2'd1, 1, 0, 0); acc(16'hCFC, 2'd2, 0, 1, 2);
        set_tgt(1, 8'h03, 8'h10, 6'h01, 2'b00); acc(16'hCFC, 2'd0, 1, 0, 0); acc(16'hCFC, 2'd2, 0, 1, 3);
        set_tgt(1, 8'h00, 8'h11, 6'h01, 2'b00); acc(16'hCFF, 2'd0, 1, 0, 0); acc(16'hCFC, 2'd2, 0, 1, 4);
        // Constrained random mix
        for (int i = 0; i < 1500; i++) begin
            int unsigned k = $urandom % 8;
            if (k < 2)
                set_tgt(($urandom % 4) != 0, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00,
                        8'($urandom), 6'($urandom), (($urandom % 4) == 0) ? 2'($urandom) : 2'b00);
            else if (k == 2)
                acc(16'hCF8 + 16'($urandom % 4), 2'($urandom), ($urandom % 2) == 0, 0, 0);
            else if (k == 3)
                acc(16'hCF0 + 16'($urandom % 16), 2'($urandom), ($urandom % 2) == 0,
                    ($urandom % 2) == 0, $urandom);
            else
                acc(16'hCFC + 16'($urandom % 4), 2'($urandom), ($urandom % 2) == 0,
                    ($urandom % 2) == 0, $urandom);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule